// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small write-back data cache. A direct-mapped main array is consulted in the same cycle a processor request is accepted. Next to it sits a four-slot, fully associative side store that keeps lines recently pushed out of the main array. When an access misses in the main array but finds its line in the side store, the two lines trade places without any memory traffic. When an access misses in both, the line is read from a simple request/acknowledge memory port. The line that was displaced from the main array moves into the side store.

Side-store slots are refilled in rotating order, so the slot reused next is always the one filled longest ago. If that slot holds a modified line, the line is written to memory before the refill read starts. A clean line in that slot is simply overwritten. With the defaults (4 KB main array, 16-byte lines, 32-bit words) the main array has 256 lines, and a line holds four words.

The processor raises `cpuReq` with the word address, the write flag and the write data. It holds all of them until `cpuDone` pulses. `cpuRdata` carries the word for a read. For a write it carries the newly stored word.

Top module: `dm_victim_cache`

## Requirements
- R1: A read whose line is in the main array raises cpuDone in the cycle after the request is first sampled, with the stored word on cpuRdata.
- R2: A write stores cpuWdata into the addressed word (word select = word address bits [1:0]) and marks the line modified; a write that hits the main array completes with the same one-cycle latency.
- R3: A main-array miss that finds its line in the side store completes two cycles after acceptance and issues no memory request.
- R4: A miss in both structures issues a memory read of the line address (word address without its two low bits) and raises cpuDone in the cycle after the memory acknowledge of that read.
- R5: A valid line displaced from the main array, by a swap or by a refill, is placed in the side store and can be hit there later.
- R6: The side store has 4 fully associative slots; refills reuse the slots in rotating order starting at slot 0, and a swap reuses the slot that hit without changing that order.
- R7: If the slot about to be reused holds a modified line, that line is written to memory (memWe high, its own line address) first, and the refill read follows immediately after the write's acknowledge.
- R8: A clean line in the reused slot is dropped without any memory write.
- R9: A line address is never present in the main array and the side store at the same time.
- R10: After reset no line is valid, cpuDone and memReq are low, and cpuDone never rises without a request in the previous cycle.
- R11: Once memReq is raised, memReq, memAddr and memWe stay constant until memAck is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWordAddr | input | ADDR_W-2 (30) | Word address of the access |
| cpuWdata | input | WORD_W (32) | Write data |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | WORD_W (32) | Read word (or the written word) |
| memReq | output | 1 | Memory transaction request, held until memAck |
| memWe | output | 1 | 1 = line write-back, 0 = line read |
| memAddr | output | LA_W (28) | Line address of the transaction |
| memWdata | output | LINE_W (128) | Line being written back |
| memAck | input | 1 | Memory completion, one cycle |
| memRdata | input | LINE_W (128) | Line returned on a read acknowledge |

## Verification
Each result has a fixed due cycle, counted from the edge that first samples the request. A main-array hit is due one cycle later and a side-store swap two cycles later. A refill is due one cycle after the memory acknowledge, so with a memory that acknowledges L cycles after the request the total is 1+L, or 1+2L when a write-back comes first. The bench raises a request just after a falling edge and counts falling edges until it sees cpuDone, so each latency is measured as an exact cycle count and compared with the value the requirements give for the cache state the bench has set up. Memory read and write counts are sampled between accesses, which shows that a swap causes no traffic, a clean slot is dropped silently and a modified slot reaches memory.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_WBACK = 2'd2,
    ST_FETCH = 2'd3
  } dvc_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hitAcc;   // access the main array on a hit
    logic swap;     // exchange main line with the side-store hit slot
    logic refill;   // install the memory line, push old line to side store
    logic wbSel;    // memory address comes from the slot being reused
  } dvc_ctrl_t;

endpackage

// File: rtl/dvc_datapath.sv
module dvc_datapath
  import dvc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16,
  parameter int VICT_N      = 4,
  localparam int WA_W       = ADDR_W - $clog2(WORD_W / 8),
  localparam int LA_W       = WA_W - $clog2(LINE_BYTES / (WORD_W / 8)),
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dvc_ctrl_t         ctrl,
  input  logic              cpuWe,
  input  logic [WA_W-1:0]   cpuWordAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic              pHit,
  output logic              vHit,
  output logic              needWb,
  output logic [LA_W-1:0]   memAddr,
  output logic [LINE_W-1:0] memWdata,
  input  logic [LINE_W-1:0] memRdata,
  output logic              cpuDone,
  output logic [WORD_W-1:0] cpuRdata
);

  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int WPL    = LINE_BYTES / (WORD_W / 8);
  localparam int WSEL_W = $clog2(WPL);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = WA_W - IDX_W - WSEL_W;
  localparam int PTR_W  = $clog2(VICT_N);

  logic [WSEL_W-1:0] wsel;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [LA_W-1:0]   reqLine;

  assign {tag, idx, wsel} = cpuWordAddr;
  assign reqLine = {tag, idx};

  // main array
  logic [TAG_W-1:0]  pTag  [LINES];
  logic [LINE_W-1:0] pData [LINES];
  logic [LINES-1:0]  pValid, pDirty;

  // side store
  logic [LA_W-1:0]   vLine [VICT_N];
  logic [LINE_W-1:0] vData [VICT_N];
  logic [VICT_N-1:0] vValid, vDirty, vHitVec;
  logic [PTR_W-1:0]  vPtr, vHitIdx, insSlot;

  assign pHit = pValid[idx] && (pTag[idx] == tag);

  generate
    for (genvar g = 0; g < VICT_N; g++) begin : g_match
      assign vHitVec[g] = vValid[g] && (vLine[g] == reqLine);
    end
  endgenerate

  assign vHit = |vHitVec;

  always_comb begin
    vHitIdx = '0;
    for (int i = 0; i < VICT_N; i++) begin
      if (vHitVec[i]) vHitIdx = i[PTR_W-1:0];
    end
  end

  assign needWb   = pValid[idx] && vValid[vPtr] && vDirty[vPtr];
  assign memAddr  = ctrl.wbSel ? vLine[vPtr] : reqLine;
  assign memWdata = vData[vPtr];

  // line source and word merge
  logic [LINE_W-1:0] srcLine, mergedLine;
  logic [WORD_W-1:0] newWord;
  logic              lineWr, insert;

  always_comb begin
    if (ctrl.swap)        srcLine = vData[vHitIdx];
    else if (ctrl.refill) srcLine = memRdata;
    else                  srcLine = pData[idx];
    mergedLine = srcLine;
    newWord    = '0;
    for (int w = 0; w < WPL; w++) begin
      if (wsel == w[WSEL_W-1:0]) begin
        if (cpuWe) mergedLine[w*WORD_W +: WORD_W] = cpuWdata;
        newWord = mergedLine[w*WORD_W +: WORD_W];
      end
    end
  end

  assign lineWr  = ctrl.hitAcc | ctrl.swap | ctrl.refill;
  assign insert  = ctrl.swap | (ctrl.refill & pValid[idx]);
  assign insSlot = ctrl.swap ? vHitIdx : vPtr;

  // storage without reset
  always_ff @(posedge clk) begin
    if (lineWr) pData[idx] <= mergedLine;
    if (ctrl.swap || ctrl.refill) pTag[idx] <= tag;
    if (insert) begin
      vLine[insSlot] <= {pTag[idx], idx};
      vData[insSlot] <= pData[idx];
    end
  end

  // state bits with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pValid   <= '0;
      pDirty   <= '0;
      vValid   <= '0;
      vDirty   <= '0;
      vPtr     <= '0;
      cpuDone  <= 1'b0;
      cpuRdata <= '0;
    end else begin
      cpuDone <= lineWr;
      if (lineWr) cpuRdata <= newWord;
      if (ctrl.hitAcc) pDirty[idx] <= pDirty[idx] | cpuWe;
      if (ctrl.swap) begin
        pValid[idx] <= 1'b1;
        pDirty[idx] <= vDirty[vHitIdx] | cpuWe;
      end
      if (ctrl.refill) begin
        pValid[idx] <= 1'b1;
        pDirty[idx] <= cpuWe;
      end
      if (insert) begin
        vValid[insSlot] <= pValid[idx];
        vDirty[insSlot] <= pDirty[idx];
      end
      if (ctrl.refill && pValid[idx]) vPtr <= vPtr + 1'b1;
    end
  end

endmodule

// File: rtl/dvc_control.sv
module dvc_control
  import dvc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      pHit,
  input  logic      vHit,
  input  logic      needWb,
  input  logic      memAck,
  output dvc_ctrl_t ctrl,
  output logic      memReq,
  output logic      memWe
);

  dvc_state_e state, nxt;

  always_comb begin
    ctrl   = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    nxt    = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (pHit)        ctrl.hitAcc = 1'b1;
          else if (vHit)   nxt = ST_SWAP;
          else if (needWb) nxt = ST_WBACK;
          else             nxt = ST_FETCH;
        end
      end
      ST_SWAP: begin
        ctrl.swap = 1'b1;
        nxt       = ST_IDLE;
      end
      ST_WBACK: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctrl.wbSel = 1'b1;
        if (memAck) nxt = ST_FETCH;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          ctrl.refill = 1'b1;
          nxt         = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import dvc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16,
  parameter int VICT_N      = 4,
  localparam int WA_W       = ADDR_W - $clog2(WORD_W / 8),
  localparam int LA_W       = WA_W - $clog2(LINE_BYTES / (WORD_W / 8)),
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [WA_W-1:0]   cpuWordAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [LA_W-1:0]   memAddr,
  output logic [LINE_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [LINE_W-1:0] memRdata
);

  dvc_ctrl_t ctrl;
  logic      pHit, vHit, needWb;

  dvc_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cpuReq (cpuReq),
    .pHit   (pHit),
    .vHit   (vHit),
    .needWb (needWb),
    .memAck (memAck),
    .ctrl   (ctrl),
    .memReq (memReq),
    .memWe  (memWe)
  );

  dvc_datapath #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_BYTES  (LINE_BYTES),
    .VICT_N      (VICT_N)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cpuWe       (cpuWe),
    .cpuWordAddr (cpuWordAddr),
    .cpuWdata    (cpuWdata),
    .pHit        (pHit),
    .vHit        (vHit),
    .needWb      (needWb),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .cpuDone     (cpuDone),
    .cpuRdata    (cpuRdata)
  );

endmodule

// File: rtl/dvc_checker.sv
module dvc_checker #(
  parameter int AW = 28
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuDone,
  input logic          memReq,
  input logic          memWe,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic          pHit,
  input logic          vHit
);

  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pHit && vHit));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R7
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> memReq && !memWe);

  // R4
  fill_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> cpuDone);

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> $past(cpuReq));

  // R3
  swap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !pHit && vHit && !memReq |=> !memReq);

endmodule

bind dm_victim_cache dvc_checker #(.AW(LA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuDone (cpuDone),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAck  (memAck),
  .memAddr (memAddr),
  .pHit    (pHit),
  .vHit    (vHit)
);

// File: tb/dm_victim_cache_bench.sv
`timescale 1ns/1ps
module dm_victim_cache_bench;

  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0;
  logic [29:0]  cpuWordAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic         cpuDone;
  logic [31:0]  cpuRdata;
  logic         memReq, memWe;
  logic [27:0]  memAddr;
  logic [127:0] memWdata;
  logic         memAck = 1'b0;
  logic [127:0] memRdata = '0;

  always #2 clk = ~clk;

  dm_victim_cache u_dm_victim_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuWordAddr(cpuWordAddr), .cpuWdata(cpuWdata), .cpuDone(cpuDone),
    .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  logic [127:0] memArr [0:1023];
  logic [31:0]  refW   [0:4095];
  int nChk = 0, nFail = 0, memRd = 0, memWr = 0;

  function automatic logic [31:0] seedWord(int a);
    return 32'h5EED_0000 ^ (a * 32'h0000_9E37);
  endfunction

  function automatic logic [11:0] wa(int t, int i, int w);
    return {t[1:0], i[7:0], w[1:0]};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  // memory model: acknowledges LAT falling edges after the request appears
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq) begin
        cnt++;
        if (cnt == LAT) begin
          memAck = 1'b1;
          cnt = 0;
          if (memWe) begin
            memArr[memAddr[9:0]] = memWdata;
            memWr++;
          end else begin
            memRdata = memArr[memAddr[9:0]];
            memRd++;
          end
        end
      end else cnt = 0;
    end
  end

  task automatic access(input bit we, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuWordAddr = {18'd0, a}; cpuWdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpuDone && lat < 200);
    rd = cpuRdata;
    cpuReq = 1'b0; cpuWe = 1'b0;
    if (we) refW[a] = wd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int lat, m0, w0;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4096; a++) begin
      refW[a] = seedWord(a);
      memArr[a >> 2][(a % 4) * 32 +: 32] = seedWord(a);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuDone == 1'b0, "R10 done after reset", cpuDone, 0);
    chk(memReq == 1'b0, "R10 memReq after reset", memReq, 0);

    // cold miss
    access(0, wa(0,0,1), 0, rd, lat);
    chk(lat == 1 + LAT, "R4 cold miss latency", lat, 1 + LAT);
    chk(rd == refW[wa(0,0,1)], "R4 refill data", rd, refW[wa(0,0,1)]);
    // hit
    access(0, wa(0,0,2), 0, rd, lat);
    chk(lat == 1, "R1 hit latency", lat, 1);
    chk(rd == refW[wa(0,0,2)], "R1 hit data", rd, refW[wa(0,0,2)]);
    // conflicting write pushes first line to side store
    access(1, wa(1,0,0), 32'hB0B0_0001, rd, lat);
    chk(lat == 1 + LAT, "R4 conflict miss latency", lat, 1 + LAT);
    // swap back
    m0 = memRd + memWr;
    access(0, wa(0,0,1), 0, rd, lat);
    chk(lat == 2, "R3 swap latency", lat, 2);
    chk(memRd + memWr == m0, "R3 no memory traffic", memRd + memWr, m0);
    chk(rd == refW[wa(0,0,1)], "R5 displaced line data", rd, refW[wa(0,0,1)]);
    access(0, wa(1,0,0), 0, rd, lat);
    chk(lat == 2, "R3 swap of modified line", lat, 2);
    chk(rd == 32'hB0B0_0001, "R2 written word kept", rd, 32'hB0B0_0001);
    // write hit
    access(1, wa(1,0,3), 32'h1234_5678, rd, lat);
    chk(lat == 1, "R2 write hit latency", lat, 1);
    access(0, wa(1,0,3), 0, rd, lat);
    chk(rd == 32'h1234_5678 && lat == 1, "R2 read after write hit", rd, 32'h1234_5678);

    // fill slots with modified lines at index 1
    w0 = memWr;
    for (int t = 0; t < 4; t++) begin
      access(1, wa(t,1,0), 32'hC000_0000 + t, rd, lat);
      chk(lat == 1 + LAT, "R6 fill latency", lat, 1 + LAT);
    end
    access(1, wa(0,2,0), 32'hD000_0000, rd, lat);
    access(1, wa(1,2,0), 32'hD000_0001, rd, lat);
    chk(memWr == w0, "R8 clean slot dropped without write", memWr, w0);
    chk(lat == 1 + LAT, "R8 clean reuse latency", lat, 1 + LAT);
    // reused slot now holds a modified line
    access(1, wa(2,2,0), 32'hD000_0002, rd, lat);
    chk(lat == 1 + 2 * LAT, "R7 write-back latency", lat, 1 + 2 * LAT);
    chk(memWr == w0 + 1, "R7 one write-back", memWr, w0 + 1);
    chk(memArr[wa(0,1,0) >> 2][31:0] == 32'hC000_0000, "R7 written-back data",
        memArr[wa(0,1,0) >> 2][31:0], 32'hC000_0000);
    access(0, wa(0,1,0), 0, rd, lat);
    chk(lat == 1 + 2 * LAT, "R6 rotating reuse", lat, 1 + 2 * LAT);
    chk(rd == 32'hC000_0000, "R6 data from memory", rd, 32'hC000_0000);
    access(0, wa(0,0,1), 0, rd, lat);
    chk(lat == 1 + 2 * LAT, "R6 oldest slot reused", lat, 1 + 2 * LAT);
    chk(rd == refW[wa(0,0,1)], "R6 evicted line data", rd, refW[wa(0,0,1)]);

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      int t = int'($urandom % 4);
      int i = int'($urandom % 6);
      int w = int'($urandom % 4);
      bit we = ($urandom % 3) == 0;
      logic [31:0] v = $urandom;
      logic [31:0] e;
      e = we ? v : refW[wa(t,i,w)];
      access(we, wa(t,i,w), v, rd, lat);
      chk(lat == 1 || lat == 2 || lat == 1 + LAT || lat == 1 + 2 * LAT,
          "R4 R11 latency class", lat, 1);
      chk(rd == e, "R1 R9 random data", rd, e);
    end
    finishRun();
  end

endmodule